// File: doc/BRIEF.md
# Shared Timer Prescaler

This block divides down a tick source for up to three timers. Software writes a load register that holds a preload value and a tick-source selector. The counter inside the block counts down one step for each tick. A tick is either every system clock cycle or a synchronized rising edge on an external timer pin. When the count passes zero, the block reloads the preload value and emits a one-cycle pulse. The timers can then use that pulse as a slower clock enable. With a preload of N, the pulse repeats once every N + 1 ticks.

The counter runs only while at least one timer is enabled and has also chosen the prescaler as its clock. A two-state machine controls this. In `ST_IDLE` the counter is stopped. The transition *arm* (some timer becomes enabled and selecting) loads the preload value and enters `ST_COUNT`. In `ST_COUNT` the counter decrements on ticks and reloads at terminal count. The transition *disarm* (no timer is enabled and selecting any more) returns the machine to `ST_IDLE`. Any later *arm* starts again from the preload value.

Top module: `tmr_prescaler`

## Requirements
- R1: The readback `reg_rdata` shows the preload value in bits 20:0 and the source field in bits 22:21. Bit 23 always reads 0. The register changes only on a cycle with `reg_wr_en` high.
- R2: After reset, `reg_rdata` is 0 and `pre_pulse` is low.
- R3: The counter is active only when some timer i has both `tmr_en[i]` and `tmr_use_pre[i]` set. While no timer meets both conditions, `pre_pulse` stays low.
- R4: On the *arm* transition, the count is loaded with the preload value N. The first pulse follows exactly N + 1 ticks after the loading edge.
- R5: With source field 00, every clock cycle is a tick, so pulses repeat every N + 1 cycles. With N = 0, the pulse is present on every cycle.
- R6: With source field 01, ticks are rising edges of `ext_pin`. The pin passes through a two-flop synchronizer and an edge detector. One pulse appears for every N + 1 rising edges, and no pulse appears while the pin is idle.
- R7: Source field values 10 and 11 behave like 00.
- R8: For N ≥ 1, each pulse is exactly one clock cycle wide.
- R9: A write during counting does not change the count in progress. The new preload value takes effect at the next reload.
- R10: The *disarm* transition stops the counter and suppresses pulses. A later *arm* restarts the count from the preload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the load register |
| reg_wdata | input | 24 | Write data: preload in bits 20:0, source select in bits 22:21 |
| reg_rdata | output | 24 | Load register readback; bit 23 reads 0 |
| tmr_en | input | 3 | Per-timer enable bits |
| tmr_use_pre | input | 3 | Per-timer bits that select the prescaler as clock source |
| ext_pin | input | 1 | External timer pin, asynchronous |
| pre_pulse | output | 1 | One-cycle prescaler output pulse |

## Verification
The assertions assume two things about `ext_pin`. It must toggle slower than a quarter of the clock rate, and it must hold each level for at least two cycles so that the edge detector sees every rising edge. The stimulus keeps the pin high for four cycles and low for four cycles, and it leaves the pin low during every internal-source run. All enable and write inputs change half a cycle away from the active edge. A write is held for exactly one cycle, which lets the register-hold property treat every other cycle as idle.

// File: rtl/tmr_pre_pkg.sv
package tmr_pre_pkg;

    typedef enum logic [1:0] {
        SRC_CLK  = 2'b00,
        SRC_PIN  = 2'b01,
        SRC_RSV2 = 2'b10,
        SRC_RSV3 = 2'b11
    } pre_src_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } pre_state_e;

endpackage

// File: rtl/pre_cfg_reg.sv
module pre_cfg_reg #(
    parameter int REG_W = 24,
    parameter int PL_W  = 21,
    parameter int SRC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [PL_W-1:0]  preload_o,
    output logic [SRC_W-1:0] src_o,
    output logic [REG_W-1:0] rdata_o
);
    localparam int FIELD_W = PL_W + SRC_W;
    localparam int RSV_W   = REG_W - FIELD_W;

    logic [PL_W-1:0]  pl_q;
    logic [SRC_W-1:0] src_q;
    logic             rsv_unused;

    assign rsv_unused = ^wdata_i[REG_W-1:FIELD_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pl_q  <= '0;
            src_q <= '0;
        end else if (wr_en_i) begin
            pl_q  <= wdata_i[PL_W-1:0];
            src_q <= wdata_i[FIELD_W-1:PL_W];
        end
    end

    assign preload_o = pl_q;
    assign src_o     = src_q;
    assign rdata_o   = {{RSV_W{1'b0}}, src_q, pl_q};

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(rdata_o)); // R1

endmodule

// File: rtl/pin_edge_sync.sv
module pin_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic tick_o
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], pin_i};
    end

    assign tick_o = sh_q[STAGES-1] & ~sh_q[STAGES];

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R8

endmodule

// File: rtl/pre_count_fsm.sv
module pre_count_fsm
    import tmr_pre_pkg::*;
#(
    parameter int CW = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active_i,
    input  logic          tick_i,
    input  logic [CW-1:0] preload_i,
    output logic          pulse_o
);
    pre_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          pulse_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (active_i)  state_d = ST_COUNT;
            ST_COUNT: if (!active_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (active_i) cnt_q <= preload_i;
                end
                ST_COUNT: begin
                    if (active_i && tick_i) begin
                        if (cnt_q == '0) begin
                            cnt_q   <= preload_i;
                            pulse_q <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                end
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign pulse_o = pulse_q;

    AST_PULSE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> $past(active_i)); // R3
    AST_LOAD_ON_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && active_i) |=> (cnt_q == $past(preload_i))); // R4
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && !tick_i) |=> $stable(cnt_q)); // R9
    AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !pulse_q); // R10

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pre_pkg::*;
#(
    parameter int N_TMR  = 3,
    parameter int REG_W  = 24,
    parameter int PL_W   = 21,
    parameter int SRC_W  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [N_TMR-1:0] tmr_en,
    input  logic [N_TMR-1:0] tmr_use_pre,
    input  logic             ext_pin,
    output logic             pre_pulse
);
    logic [PL_W-1:0]  preload;
    logic [SRC_W-1:0] src_sel;
    logic [N_TMR-1:0] want;
    logic             active;
    logic             pin_tick;
    logic             tick;

    for (genvar i = 0; i < N_TMR; i++) begin : g_want
        assign want[i] = tmr_en[i] & tmr_use_pre[i];
    end
    assign active = |want;

    pre_cfg_reg #(.REG_W(REG_W), .PL_W(PL_W), .SRC_W(SRC_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (reg_wr_en),
        .wdata_i   (reg_wdata),
        .preload_o (preload),
        .src_o     (src_sel),
        .rdata_o   (reg_rdata)
    );

    pin_edge_sync #(.STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin),
        .tick_o (pin_tick)
    );

    always_comb begin
        unique case (pre_src_e'(src_sel))
            SRC_PIN: tick = pin_tick;
            default: tick = 1'b1;
        endcase
    end

    pre_count_fsm #(.CW(PL_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (active),
        .tick_i    (tick),
        .preload_i (preload),
        .pulse_o   (pre_pulse)
    );

    AST_NO_PULSE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !pre_pulse); // R3
    AST_RSV_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_wr_en) |=> (reg_rdata[REG_W-1] == 1'b0)); // R1

endmodule

// File: tb/tb_tmr_prescaler.sv
module tb_tmr_prescaler;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    localparam int V_PL  [NV] = '{3, 0, 6, 1, 2, 2};
    localparam int V_SRC [NV] = '{0, 0, 2, 3, 0, 0};
    localparam int V_EN  [NV] = '{1, 2, 4, 7, 7, 0};
    localparam int V_SEL [NV] = '{1, 2, 4, 5, 0, 7};
    localparam int V_CYC [NV] = '{17, 6, 22, 9, 10, 10};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic [2:0]  tmr_en = '0;
    logic [2:0]  tmr_use_pre = '0;
    logic        ext_pin = 1'b0;
    logic        pre_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_prescaler dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tmr_en(tmr_en), .tmr_use_pre(tmr_use_pre),
        .ext_pin(ext_pin), .pre_pulse(pre_pulse)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [23:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic disarm();
        @(negedge clk);
        tmr_en = '0;
        tmr_use_pre = '0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD*100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int pulses, first, prev, wide;
        repeat (3) @(negedge clk);
        chk("R2 rdata", reg_rdata, 0);
        chk("R2 pulse", pre_pulse, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 rdata after release", reg_rdata, 0);

        wr(24'hFFFFFF);
        chk("R1 reserved bit", reg_rdata, 24'h7FFFFF);
        wr(24'h4A5A5A);
        chk("R1 fields", reg_rdata, 24'h4A5A5A);
        repeat (3) @(negedge clk);
        chk("R1 hold", reg_rdata, 24'h4A5A5A);

        for (int v = 0; v < NV; v++) begin
            int exp_n, exp_first;
            disarm();
            wr(24'(V_SRC[v]) << 21 | 24'(V_PL[v]));
            @(negedge clk);
            tmr_en = 3'(V_EN[v]);
            tmr_use_pre = 3'(V_SEL[v]);
            pulses = 0; first = -1; prev = 0; wide = 0;
            for (int i = 0; i < V_CYC[v]; i++) begin
                @(negedge clk);
                if (pre_pulse) begin
                    pulses++;
                    if (first < 0) first = i;
                    if (prev) wide++;
                end
                prev = pre_pulse;
            end
            if ((V_EN[v] & V_SEL[v]) != 0) begin
                exp_n = (V_CYC[v] - 1) / (V_PL[v] + 1);
                exp_first = V_PL[v] + 1;
            end else begin
                exp_n = 0;
                exp_first = -1;
            end
            chk($sformatf("R5 R7 R3 vector %0d pulse count", v), pulses, exp_n);
            chk($sformatf("R4 vector %0d first pulse", v), first, exp_first);
            if (V_PL[v] >= 1) chk($sformatf("R8 vector %0d width", v), wide, 0);
        end

        // R9: write mid-count
        disarm();
        wr(24'd4);
        @(negedge clk);
        tmr_en = 3'b001; tmr_use_pre = 3'b001;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk($sformatf("R9 sample %0d", i), pre_pulse, (i == 5 || i == 7 || i == 9));
            if (i == 1) begin reg_wr_en = 1'b1; reg_wdata = 24'd1; end
            else reg_wr_en = 1'b0;
        end

        // R10: disarm and re-arm restarts from preload
        disarm();
        wr(24'd5);
        @(negedge clk);
        tmr_en = 3'b010; tmr_use_pre = 3'b010;
        repeat (3) @(negedge clk);
        tmr_en = 3'b000;
        pulses = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (pre_pulse) pulses++;
        end
        chk("R10 no pulse while disarmed", pulses, 0);
        tmr_en = 3'b010;
        first = -1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (pre_pulse && first < 0) first = i;
        end
        chk("R10 restart first pulse", first, 6);

        // R6: external pin source
        disarm();
        wr((24'd1 << 21) | 24'd2);
        @(negedge clk);
        tmr_en = 3'b100; tmr_use_pre = 3'b100;
        pulses = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pre_pulse) pulses++;
        end
        chk("R6 idle pin no pulse", pulses, 0);
        pulses = 0; prev = 0; wide = 0;
        for (int e = 0; e < 9; e++) begin
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                ext_pin = (k < 4);
                if (pre_pulse) begin pulses++; if (prev) wide++; end
                prev = pre_pulse;
            end
        end
        ext_pin = 1'b0;
        repeat (10) begin
            @(negedge clk);
            if (pre_pulse) begin pulses++; if (prev) wide++; end
            prev = pre_pulse;
        end
        chk("R6 pulses per pin edges", pulses, 3);
        chk("R8 external pulse width", wide, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule